// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides what kind of access a memory request may make to a page, given the access rights of the page's protection domain and the two-bit permission field from the page descriptor. It takes the domain rights code, the permission field, two legacy control bits (a system-protection bit and a ROM-protection bit) and the processor's privilege state. It reduces them to one of three access levels: none, read-only or read/write. Comparing that level with the requested operation, and raising any fault, is left to the logic that uses the result.

A request is presented with `req_valid`. The decision is registered and appears one clock later with `rsp_valid`. A domain rights code that is reserved yields no access. It also sets a sticky error flag that only reset clears.

Top module: `page_perm_judge`

## Requirements
- R1: `rsp_level` encodes 0 as no access, 1 as read-only and 2 as read/write. The value 3 never appears.
- R2: A domain code of 0 (no rights) gives level 0, whatever the permission field, control bits and mode are.
- R3: A domain code of 3 (manager) gives level 2, whatever the permission field, control bits and mode are.
- R4: With domain code 1 (client) and permission field 0, the level depends on the system bit `sys_prot` and the ROM bit `rom_prot`. Both clear gives 0. System bit alone gives 1 when privileged and 0 in user mode. ROM bit alone gives 1 in both modes. Both set gives 0.
- R5: With domain code 1 and permission field 1, the level is 2 when privileged and 0 in user mode.
- R6: With domain code 1 and permission field 2, the level is 2 when privileged and 1 in user mode.
- R7: With domain code 1 and permission field 3, the level is 2 in both modes.
- R8: A request counts as user mode when `cpu_user` is 1 or `force_user` is 1. It counts as privileged only when both are 0.
- R9: Domain code 2 is reserved. It gives level 0 and sets `dom_err` in the same cycle that the result appears. `dom_err` then stays at 1 until reset.
- R10: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` at 1. `rsp_level` changes only on accepted requests. Reset drives `rsp_valid`, `rsp_level` and `dom_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| dom_code | input | 2 | Domain rights: 0 none, 1 client, 2 reserved, 3 manager |
| ap_code | input | 2 | Page permission field |
| sys_prot | input | 1 | System-protection control bit |
| rom_prot | input | 1 | ROM-protection control bit |
| cpu_user | input | 1 | Processor is in user mode |
| force_user | input | 1 | Treat this access as a user access (translated load/store) |
| rsp_valid | output | 1 | Result valid |
| rsp_level | output | 2 | Access level: 0 none, 1 read-only, 2 read/write |
| dom_err | output | 1 | Sticky flag: a reserved domain code was seen |

## Verification
The bench sweeps all 256 combinations of domain code, permission field, the two control bits and the two mode inputs. Doing so separates the domain gating from the client permission table. It also shows whether either mode input alone is enough to force user treatment. The sweep visits the reserved domain code only partway through, so the error flag can be seen low before that point and high for the rest of the run. Idle cycles between requests show that the level holds. A final reset shows that the sticky flag clears.

// File: rtl/page_perm_judge.sv
module page_perm_judge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] dom_code,
  input  logic [1:0] ap_code,
  input  logic       sys_prot,
  input  logic       rom_prot,
  input  logic       cpu_user,
  input  logic       force_user,
  output logic       rsp_valid,
  output logic [1:0] rsp_level,
  output logic       dom_err
);
  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_RO   = 2'd1;
  localparam logic [1:0] LVL_RW   = 2'd2;

  logic       as_user;
  logic [1:0] client_lvl;
  logic [1:0] next_lvl;
  logic       rsv_hit;

  assign as_user = cpu_user | force_user;
  assign rsv_hit = req_valid && (dom_code == 2'd2);

  always_comb begin
    client_lvl = LVL_NONE;
    unique case (ap_code)
      2'd0: begin
        unique case ({rom_prot, sys_prot})
          2'b01:   client_lvl = as_user ? LVL_NONE : LVL_RO;
          2'b10:   client_lvl = LVL_RO;
          default: client_lvl = LVL_NONE;
        endcase
      end
      2'd1: client_lvl = as_user ? LVL_NONE : LVL_RW;
      2'd2: client_lvl = as_user ? LVL_RO : LVL_RW;
      default: client_lvl = LVL_RW;
    endcase
  end

  always_comb begin
    unique case (dom_code)
      2'd1:    next_lvl = client_lvl;
      2'd3:    next_lvl = LVL_RW;
      default: next_lvl = LVL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_level <= LVL_NONE;
      dom_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_level <= next_lvl;
      if (rsv_hit) dom_err <= 1'b1;
    end
  end
endmodule

// File: rtl/page_perm_judge_chk.sv
module page_perm_judge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] dom_code,
  input logic [1:0] ap_code,
  input logic       cpu_user,
  input logic       force_user,
  input logic       rsp_valid,
  input logic [1:0] rsp_level,
  input logic       dom_err
);
  p_no_level3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_level != 2'd3);
  p_none_dom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dom_code == 2'd0) |=> rsp_level == 2'd0);
  p_mgr_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dom_code == 2'd3) |=> rsp_level == 2'd2);
  p_ap3_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dom_code == 2'd1 && ap_code == 2'd3) |=> rsp_level == 2'd2);
  p_ap1_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dom_code == 2'd1 && ap_code == 2'd1 && (cpu_user || force_user))
      |=> rsp_level == 2'd0);
  p_rsv_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dom_code == 2'd2) |=> (dom_err && rsp_level == 2'd0));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dom_err |=> dom_err);
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_level)));
endmodule

bind page_perm_judge page_perm_judge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dom_code(dom_code),
  .ap_code(ap_code), .cpu_user(cpu_user), .force_user(force_user),
  .rsp_valid(rsp_valid), .rsp_level(rsp_level), .dom_err(dom_err)
);

// File: tb/page_perm_judge_bench.sv
module page_perm_judge_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] dom_code = 2'd0;
  logic [1:0] ap_code = 2'd0;
  logic sys_prot = 1'b0, rom_prot = 1'b0, cpu_user = 1'b0, force_user = 1'b0;
  logic rsp_valid, dom_err;
  logic [1:0] rsp_level;

  int n_cmp = 0, n_bad = 0;
  bit rsv_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_perm_judge u_page_perm_judge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dom_code(dom_code),
    .ap_code(ap_code), .sys_prot(sys_prot), .rom_prot(rom_prot),
    .cpu_user(cpu_user), .force_user(force_user), .rsp_valid(rsp_valid),
    .rsp_level(rsp_level), .dom_err(dom_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected level: privileged and user values per client permission code
  function automatic int model(int d, int a, int s, int r, int u);
    int priv_v, user_v;
    if (d == 0 || d == 2) return 0;
    if (d == 3) return 2;
    case (a)
      3: begin priv_v = 2; user_v = 2; end
      2: begin priv_v = 2; user_v = 1; end
      1: begin priv_v = 2; user_v = 0; end
      default: begin
        priv_v = (s + r == 1) ? 1 : 0;
        user_v = (r == 1 && s == 0) ? 1 : 0;
      end
    endcase
    return u ? user_v : priv_v;
  endfunction

  initial begin
    int last;
    repeat (3) @(negedge clk);
    check("R10 reset valid", rsp_valid, 0);
    check("R10 reset level", rsp_level, 0);
    check("R9 reset err", dom_err, 0);
    rst_n = 1'b1;
    last = 0;
    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 16; c++) begin
          int e;
          string tag;
          @(negedge clk);
          dom_code = 2'(d); ap_code = 2'(a);
          sys_prot = c[0]; rom_prot = c[1]; cpu_user = c[2]; force_user = c[3];
          req_valid = 1'b1;
          e = model(d, a, c[0], c[1], c[2] | c[3]);
          if (d == 2) rsv_seen = 1;
          @(negedge clk);
          req_valid = 1'b0;
          tag = (d == 0) ? "R2" : (d == 2) ? "R9" : (d == 3) ? "R3" :
                (a == 0) ? "R4" : (a == 1) ? "R5" : (a == 2) ? "R6" : "R7";
          if (c[3:2] != 0 && d == 1) tag = {tag, "/R8"};
          check({tag, " level"}, rsp_level, e);
          check("R10 valid after req", rsp_valid, 1);
          check("R9 err flag", dom_err, rsv_seen);
          check("R1 no level 3", rsp_level == 3, 0);
          last = e;
          @(negedge clk);
          check("R10 valid idle", rsp_valid, 0);
          check("R10 level hold", rsp_level, last);
        end
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 err cleared by reset", dom_err, 0);
    check("R10 level cleared by reset", rsp_level, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule